// File: doc/BRIEF.md
# Crossing-Ordered Hit Reorder Buffer

Hits arrive tagged with the beam crossing that produced them, but not in crossing order. The buffer sorts them without any comparators: the low bits of the crossing number select a slot in a RAM. Each slot holds a small fixed number of hit entries. A per-slot counter records how many entries in that slot are occupied. A read sequencer then walks the slots one after another in crossing order. It emits every stored hit of a crossing in consecutive cycles, and frames each hit into a wider output word.

An internal crossing counter advances once per strobe on `bco_tick_i`. A hit is stored only while its crossing is still young, that is, less than `WINDOW` crossings behind the counter. Once a crossing reaches that age it is read out and its slot is freed for reuse. Crossings that hold no hits produce no output words. Hits beyond a slot's capacity are dropped and raise a sticky flag.

Top module: `bco_reorder_buf`

## Requirements
- R1: A hit is stored only when age = (crossing counter − hit crossing) mod 2^TS_W is below WINDOW (16). Later hits and hits with a crossing number ahead of the counter are discarded: they produce no output word and do not set overflow_o.
- R2: All stored hits of one crossing leave on consecutive cycles, one word per cycle, in the order they were accepted.
- R3: Crossings are emitted in increasing modular order. Crossing X is read once the counter reaches X+WINDOW. The sequencer spends one cycle on an empty crossing and one cycle per hit; tick strobes are at least DEPTH+2 cycles apart.
- R4: The output word is bit 31 last flag, bits 30:24 zero, bits 23:16 crossing number, bits 15:0 hit payload.
- R5: Bit 31 is set only on the final hit of a crossing, and a crossing with no stored hits emits no word.
- R6: A crossing stores at most DEPTH (4) hits. Further hits to that crossing are dropped, and overflow_o goes high at the clock edge that drops one and stays high until reset.
- R7: After a crossing is read out its slot starts empty, so a crossing 2^SLOT_W (32) later that maps to the same slot sees no stale hits.
- R8: During and right after reset out_valid_o and overflow_o are 0, the crossing counter is 0, and no slot holds hits.
- R9: The crossing counter advances by one on each cycle with bco_tick_i high and wraps modulo 2^TS_W (256), with ordering and window intact across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bco_tick_i | input | 1 | One-cycle strobe advancing the crossing counter |
| hit_valid_i | input | 1 | Hit present this cycle |
| hit_bco_i | input | 8 | Crossing number of the hit |
| hit_data_i | input | 16 | Hit payload |
| out_valid_o | output | 1 | Output word valid |
| out_word_o | output | 32 | Framed hit: last flag, crossing, payload |
| overflow_o | output | 1 | Sticky: a hit was dropped for lack of slot space |

## Verification
A hit sampled at edge E is stored at E. The tick edge that brings the counter to X+WINDOW makes crossing X due. The first word of X is registered at the next edge if the sequencer is idle, and later words follow one per edge. overflow_o rises at the same edge that drops a hit. The bench drives inputs at the falling edge and steps its own queue model with those inputs, in the same order the hardware applies them at the next rising edge: read, then write, then tick. At the falling edge after that it compares valid, word and overflow, so every comparison falls in the cycle where the result is due.

// File: rtl/bco_reorder_pkg.sv
package bco_reorder_pkg;
  localparam int TS_W   = 8;
  localparam int PAY_W  = 16;
  localparam int OUT_W  = 32;
  localparam int DEPTH  = 4;
  localparam int WINDOW = 16;
  localparam int SLOT_W = 5;
endpackage

// File: rtl/bco_wr_ctrl.sv
module bco_wr_ctrl #(
  parameter int TS_W   = bco_reorder_pkg::TS_W,
  parameter int WINDOW = bco_reorder_pkg::WINDOW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            hit_valid_i,
  input  logic [TS_W-1:0] hit_bco_i,
  output logic [TS_W-1:0] cur_bco_o,
  output logic            in_window_o
);
  logic [TS_W-1:0] cur_q;
  logic [TS_W-1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (tick_i) cur_q <= cur_q + TS_W'(1);
  end

  // modular age, kept at TS_W bits so the wrap is preserved
  assign age         = cur_q - hit_bco_i;
  assign in_window_o = hit_valid_i && (age < TS_W'(WINDOW));
  assign cur_bco_o   = cur_q;

  p_tick_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cur_bco_o == $past(cur_bco_o) + TS_W'(1));
  p_tick_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cur_bco_o));
endmodule

// File: rtl/bco_slot_table.sv
module bco_slot_table #(
  parameter int SLOT_W = bco_reorder_pkg::SLOT_W,
  parameter int DEPTH  = bco_reorder_pkg::DEPTH,
  localparam int NSLOT = 2 ** SLOT_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [SLOT_W-1:0] inc_slot_i,
  output logic              inc_ok_o,
  output logic [IDX_W-1:0]  inc_idx_o,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] clr_slot_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              overflow_o
);
  logic [CNT_W-1:0] cnt_q [NSLOT];
  logic [CNT_W-1:0] inc_cnt;
  logic             ovf_q;

  assign inc_cnt   = cnt_q[inc_slot_i];
  assign inc_ok_o  = inc_i && (inc_cnt < CNT_W'(DEPTH));
  assign inc_idx_o = inc_cnt[IDX_W-1:0];
  assign rd_cnt_o  = cnt_q[rd_slot_i];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q[g] <= '0;
      else if (clr_i && clr_slot_i == SLOT_W'(g))
        cnt_q[g] <= '0;
      else if (inc_ok_o && inc_slot_i == SLOT_W'(g))
        cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ovf_q <= 1'b0;
    else if (inc_i && !inc_ok_o)  ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  p_full_slot_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && inc_cnt == CNT_W'(DEPTH) && !clr_i) |=> cnt_q[$past(inc_slot_i)] == CNT_W'(DEPTH));
  p_full_slot_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && inc_cnt == CNT_W'(DEPTH)) |=> overflow_o);
  p_clear_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q[$past(clr_slot_i)] == '0);
endmodule

// File: rtl/bco_hit_ram.sv
module bco_hit_ram #(
  parameter int AW    = 7,
  parameter int DW    = bco_reorder_pkg::PAY_W,
  localparam int WORDS = 2 ** AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bco_rd_seq.sv
module bco_rd_seq #(
  parameter int TS_W   = bco_reorder_pkg::TS_W,
  parameter int SLOT_W = bco_reorder_pkg::SLOT_W,
  parameter int DEPTH  = bco_reorder_pkg::DEPTH,
  parameter int WINDOW = bco_reorder_pkg::WINDOW,
  parameter int PAY_W  = bco_reorder_pkg::PAY_W,
  parameter int OUT_W  = bco_reorder_pkg::OUT_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PAD_W = OUT_W - 1 - TS_W - PAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TS_W-1:0]   cur_bco_i,
  input  logic [CNT_W-1:0]  slot_cnt_i,
  input  logic [PAY_W-1:0]  ram_rdata_i,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              clr_o,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_word_o
);
  // start one crossing short of due so the pointer trails the counter by WINDOW-1
  localparam logic [TS_W-1:0] RD_INIT = TS_W'(2 ** TS_W - WINDOW + 1);

  logic [TS_W-1:0]  rd_bco_q;
  logic [IDX_W-1:0] idx_q;
  logic [TS_W-1:0]  rd_age;
  logic             due, empty, last, emit, advance;
  logic             out_valid_q;
  logic [OUT_W-1:0] out_word_q;

  assign rd_age  = cur_bco_i - rd_bco_q;
  assign due     = rd_age >= TS_W'(WINDOW);
  assign empty   = slot_cnt_i == '0;
  assign last    = CNT_W'(idx_q) == slot_cnt_i - CNT_W'(1);
  assign emit    = due && !empty;
  assign advance = due && (empty || last);
  assign clr_o   = emit && last;

  assign rd_slot_o = rd_bco_q[SLOT_W-1:0];
  assign rd_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bco_q <= RD_INIT;
      idx_q    <= '0;
    end else if (advance) begin
      rd_bco_q <= rd_bco_q + TS_W'(1);
      idx_q    <= '0;
    end else if (emit) begin
      idx_q    <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_word_q  <= '0;
    end else begin
      out_valid_q <= emit;
      if (emit) out_word_q <= {last, {PAD_W{1'b0}}, rd_bco_q, ram_rdata_i};
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_word_o  = out_word_q;

  logic [TS_W-1:0] out_bco;
  logic [TS_W-1:0] out_age;
  assign out_bco = out_word_q[PAY_W +: TS_W];
  assign out_age = cur_bco_i - out_bco;

  p_group_contig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_word_o[OUT_W-1]) |=> (out_valid_o && out_bco == $past(out_bco)));
  p_release_lag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_age >= TS_W'(WINDOW));
  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_word_o[OUT_W-2 -: PAD_W] == '0);
endmodule

// File: rtl/bco_reorder_buf.sv
module bco_reorder_buf #(
  parameter int TS_W   = bco_reorder_pkg::TS_W,
  parameter int PAY_W  = bco_reorder_pkg::PAY_W,
  parameter int OUT_W  = bco_reorder_pkg::OUT_W,
  parameter int DEPTH  = bco_reorder_pkg::DEPTH,
  parameter int WINDOW = bco_reorder_pkg::WINDOW,
  parameter int SLOT_W = bco_reorder_pkg::SLOT_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = SLOT_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bco_tick_i,
  input  logic             hit_valid_i,
  input  logic [TS_W-1:0]  hit_bco_i,
  input  logic [PAY_W-1:0] hit_data_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_word_o,
  output logic             overflow_o
);
  logic [TS_W-1:0]   cur_bco;
  logic              in_window;
  logic              inc_ok;
  logic [IDX_W-1:0]  inc_idx;
  logic              clr;
  logic [SLOT_W-1:0] rd_slot;
  logic [IDX_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  rd_cnt;
  logic [PAY_W-1:0]  ram_rdata;
  logic [SLOT_W-1:0] wr_slot;

  assign wr_slot = hit_bco_i[SLOT_W-1:0];

  bco_wr_ctrl #(.TS_W(TS_W), .WINDOW(WINDOW)) u_wr (
    .clk_i, .rst_ni,
    .tick_i      (bco_tick_i),
    .hit_valid_i (hit_valid_i),
    .hit_bco_i   (hit_bco_i),
    .cur_bco_o   (cur_bco),
    .in_window_o (in_window)
  );

  bco_slot_table #(.SLOT_W(SLOT_W), .DEPTH(DEPTH)) u_tbl (
    .clk_i, .rst_ni,
    .inc_i      (in_window),
    .inc_slot_i (wr_slot),
    .inc_ok_o   (inc_ok),
    .inc_idx_o  (inc_idx),
    .clr_i      (clr),
    .clr_slot_i (rd_slot),
    .rd_slot_i  (rd_slot),
    .rd_cnt_o   (rd_cnt),
    .overflow_o (overflow_o)
  );

  bco_hit_ram #(.AW(AW), .DW(PAY_W)) u_ram (
    .clk_i,
    .we_i    (inc_ok),
    .waddr_i ({wr_slot, inc_idx}),
    .wdata_i (hit_data_i),
    .raddr_i ({rd_slot, rd_idx}),
    .rdata_o (ram_rdata)
  );

  bco_rd_seq #(
    .TS_W(TS_W), .SLOT_W(SLOT_W), .DEPTH(DEPTH),
    .WINDOW(WINDOW), .PAY_W(PAY_W), .OUT_W(OUT_W)
  ) u_seq (
    .clk_i, .rst_ni,
    .cur_bco_i   (cur_bco),
    .slot_cnt_i  (rd_cnt),
    .ram_rdata_i (ram_rdata),
    .rd_slot_o   (rd_slot),
    .rd_idx_o    (rd_idx),
    .clr_o       (clr),
    .out_valid_o (out_valid_o),
    .out_word_o  (out_word_o)
  );

  // a dropped late/future hit must never reach the table
  p_late_no_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_valid_i && !in_window) |-> !inc_ok);
  p_reset_quiet_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && !overflow_o));
endmodule

// File: tb/tb_bco_reorder_buf.sv
`timescale 1ns/1ps
module tb_bco_reorder_buf;
  localparam int W = 16;
  localparam int D = 4;
  localparam int NCYC = 3800;

  logic        clk = 1'b0;
  logic        rst_ni, tick, hv;
  logic [7:0]  hb;
  logic [15:0] hd;
  logic        out_valid, ovf;
  logic [31:0] out_word;

  always #2 clk = ~clk;

  bco_reorder_buf dut (
    .clk_i(clk), .rst_ni(rst_ni), .bco_tick_i(tick),
    .hit_valid_i(hv), .hit_bco_i(hb), .hit_data_i(hd),
    .out_valid_o(out_valid), .out_word_o(out_word), .overflow_o(ovf)
  );

  int          n_cmp = 0, n_bad = 0;
  logic [15:0] qm [256][$];
  int          cur, rd;
  bit          exp_v, exp_ovf, done;
  logic [31:0] exp_w;
  logic [31:0] lf;
  logic [31:0] r;
  logic [15:0] p;
  bit          lst;
  string       tag;

  function automatic logic [31:0] rnd();
    lf = lf * 32'd1664525 + 32'd1013904223;
    return lf;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (%s) actual=%h expected=%h", req, tag, act, expv);
    end
  endtask

  task automatic model_step();
    exp_v = 1'b0;
    if (((cur - rd) & 255) >= W) begin
      if (qm[rd].size() == 0) rd = (rd + 1) & 255;
      else begin
        p     = qm[rd].pop_front();
        lst   = (qm[rd].size() == 0);
        exp_v = 1'b1;
        exp_w = {lst, 7'd0, 8'(rd), p};
        if (lst) rd = (rd + 1) & 255;
      end
    end
    if (hv && (((cur - int'(hb)) & 255) < W)) begin
      if (qm[hb].size() < D) qm[hb].push_back(hd);
      else exp_ovf = 1'b1;
    end
    if (tick) cur = (cur + 1) & 255;
  endtask

  initial begin
    rst_ni = 1'b0; tick = 1'b0; hv = 1'b0; hb = '0; hd = '0;
    lf = 32'd7; done = 1'b0;
    tag = "R8 reset";
    repeat (4) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R8", 32'(out_valid), 0);
      check(ovf === 1'b0, "R8", 32'(ovf), 0);
    end
    cur = 0; rd = 241; exp_v = 1'b0; exp_ovf = 1'b0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (cyc == 0) rst_ni = 1'b1;
      else begin
        check(out_valid === exp_v, "R3 valid", 32'(out_valid), 32'(exp_v));
        if (exp_v && out_valid) begin
          check(out_word[30:0] === exp_w[30:0], "R4 word", out_word, exp_w);
          check(out_word[31] === exp_w[31], "R5 last", 32'(out_word[31]), 32'(exp_w[31]));
        end
        check(ovf === exp_ovf, "R6 overflow", 32'(ovf), 32'(exp_ovf));
      end
      r    = rnd();
      tick = (cyc % 8 == 7);
      hd   = r[31:16];
      if (cyc < 600) begin
        tag = "R2 R3 in-window";
        hv  = (r[2:0] == 3'd0);
        hb  = 8'(cur - int'(r[6:3]) % 14);
      end else if (cyc < 1000) begin
        tag = "R1 window edge";
        hv  = (r[2:0] == 3'd0);
        if (r[3]) hb = 8'(cur + 1 + int'(r[5:4]));
        else      hb = 8'(cur - int'(r[10:6]));
      end else if (cyc < 1400) begin
        tag = "R6 overflow";
        hv  = 1'b1;
        hb  = 8'(cur - int'(r[4]));
      end else if (cyc < 3600) begin
        tag = "R5 R7 R9 wrap";
        hv  = (r[2:1] == 2'd0);
        hb  = 8'(cur - int'(r[8:5]));
      end else begin
        tag = "R3 drain";
        hv  = 1'b0;
      end
      model_step();
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule